// File: doc/BRIEF.md
# Scaled-Index Address Generation Unit

This unit turns a decoded two-operand descriptor into the locations of a destination and a source operand for a 32-bit machine whose instructions mix registers and memory. One operand slot, the r/m slot, names either a register or a memory location. A memory location is formed from an optional base register value, an optional index register value multiplied by 1, 2, 4 or 8, and a signed 32-bit displacement. The other slots are a plain register number and an immediate. The register file is read outside the unit, and the values arrive on input ports.

A 2-bit form code picks which slot becomes the destination and which becomes the source. Each resulting location carries a 2-bit kind (immediate, register or memory) together with a register number or a data word (the immediate or the computed address). A separate address-only output serves a load-effective-address operation. It gives the source's computed address when the source is a memory operand and zero when the source is anything else. A request to write a destination that turns out to be an immediate raises an error flag instead of being silently accepted. All results are registered. They appear one clock after the request, marked by a valid strobe.

Top module: `scaled_agu`

## Requirements
- R1: While `rst` is high, and on the first rising edge after it, `out_valid` and `wr_err` are 0 and every kind, register and data output is 0.
- R2: The index term is `idx_val` shifted left by `scale` (factor 1, 2, 4 or 8 for codes 0..3).
- R3: When `idx_en` is 0, the index term is zero, whatever `idx_val` and `scale` hold.
- R4: When `base_en` is 0, the base term is zero, whatever `base_val` holds.
- R5: A memory address is index term + base term + `disp`, truncated to 32 bits (sums wrap modulo 2^32).
- R6: Kind encoding is 2'b00 immediate, 2'b01 register, 2'b10 memory; 2'b11 never appears while `out_valid` is 1. A register location gives its number on the `*_reg` output and 0 on `*_data`. An immediate gives 0 on `*_reg` and `imm` on `*_data`. A memory location gives 0 on `*_reg` and its address on `*_data`. The r/m slot is memory when `rm_is_mem` is 1 and otherwise register `rm_reg`.
- R7: `lea_addr` equals the source's computed address when the source kind is memory, and 0 otherwise.
- R8: Form 2'b00: destination r/m, source immediate. 2'b01: destination r/m, source register `reg_num`. 2'b10: destination register `reg_num`, source r/m. 2'b11: destination and source both the immediate.
- R9: `wr_err` is 1 exactly when the accepted request had `dst_wr` = 1 and its destination kind is immediate.
- R10: A request with `in_valid` = 1 produces its results, and `out_valid` = 1, after the next rising edge. A cycle with `in_valid` = 0 clears `out_valid` and `wr_err` and leaves all other outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| form | input | 2 | Operand routing form (R8) |
| rm_is_mem | input | 1 | r/m slot is a memory reference |
| rm_reg | input | 3 | Register number of r/m slot when not memory |
| base_en | input | 1 | Base register present |
| base_val | input | 32 | Base register value |
| idx_en | input | 1 | Index register present |
| idx_val | input | 32 | Index register value |
| scale | input | 2 | Index scale code |
| disp | input | 32 | Displacement |
| reg_num | input | 3 | Register slot number |
| imm | input | 32 | Immediate value |
| dst_wr | input | 1 | Operation intends to write its destination |
| out_valid | output | 1 | Results valid |
| dst_kind | output | 2 | Destination kind |
| dst_reg | output | 3 | Destination register number |
| dst_data | output | 32 | Destination immediate or address |
| src_kind | output | 2 | Source kind |
| src_reg | output | 3 | Source register number |
| src_data | output | 32 | Source immediate or address |
| lea_addr | output | 32 | Address-only result of the source |
| wr_err | output | 1 | Write to an immediate requested |

## Verification
Every cycle, the assertions check several rules. The valid strobe must follow the request strobe by one clock. No illegal kind code may appear. The error flag may rise only alongside an immediate destination. A non-memory source must give a zero address-only result. Idle cycles must leave the data outputs untouched. The arithmetic itself can only be shown by the bench's scenarios: the shift-based scaling, the fallback to zero for an absent base or index, and the wrap of the sum. The same holds for the exact routing of each form. The bench compares each of these against an independent multiply-and-add model under random and directed operand mixes.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    KIND_IMM = 2'b00,
    KIND_REG = 2'b01,
    KIND_MEM = 2'b10
  } opkind_e;

  typedef enum logic [1:0] {
    FORM_RM_IMM = 2'b00,
    FORM_RM_REG = 2'b01,
    FORM_REG_RM = 2'b10,
    FORM_IMM    = 2'b11
  } form_e;

endpackage

// File: rtl/agu_ea_calc.sv
module agu_ea_calc #(
  parameter int AW  = 32,
  parameter int SCW = 2
) (
  input  logic           base_en,
  input  logic [AW-1:0]  base_val,
  input  logic           idx_en,
  input  logic [AW-1:0]  idx_val,
  input  logic [SCW-1:0] scale,
  input  logic [AW-1:0]  disp,
  output logic [AW-1:0]  addr
);

  localparam int NSC = 1 << SCW;

  logic [AW-1:0] shifted [NSC];
  logic [AW-1:0] idx_term;
  logic [AW-1:0] base_term;

  // one pre-shifted copy per scale code; the code selects among them
  for (genvar g = 0; g < NSC; g++) begin : g_scale
    assign shifted[g] = idx_val << g;
  end

  always_comb begin
    idx_term  = idx_en  ? shifted[scale] : '0;
    base_term = base_en ? base_val       : '0;
    addr      = idx_term + base_term + disp;
  end

endmodule

// File: rtl/agu_operand_sel.sv
module agu_operand_sel
  import agu_pkg::*;
#(
  parameter int AW  = 32,
  parameter int RNW = 3
) (
  input  logic [1:0]     form,
  input  logic           rm_is_mem,
  input  logic [RNW-1:0] rm_reg,
  input  logic [AW-1:0]  rm_addr,
  input  logic [RNW-1:0] reg_num,
  input  logic [AW-1:0]  imm,
  output logic [1:0]     dst_kind,
  output logic [RNW-1:0] dst_reg,
  output logic [AW-1:0]  dst_data,
  output logic [1:0]     src_kind,
  output logic [RNW-1:0] src_reg,
  output logic [AW-1:0]  src_data,
  output logic [AW-1:0]  lea
);

  // the three candidate locations
  logic [1:0]     rm_k, rg_k, im_k;
  logic [RNW-1:0] rm_r, rg_r, im_r;
  logic [AW-1:0]  rm_d, rg_d, im_d;

  always_comb begin
    if (rm_is_mem) begin
      rm_k = KIND_MEM;
      rm_r = '0;
      rm_d = rm_addr;
    end else begin
      rm_k = KIND_REG;
      rm_r = rm_reg;
      rm_d = '0;
    end
    rg_k = KIND_REG;
    rg_r = reg_num;
    rg_d = '0;
    im_k = KIND_IMM;
    im_r = '0;
    im_d = imm;
  end

  always_comb begin
    unique case (form_e'(form))
      FORM_RM_IMM: begin
        dst_kind = rm_k; dst_reg = rm_r; dst_data = rm_d;
        src_kind = im_k; src_reg = im_r; src_data = im_d;
      end
      FORM_RM_REG: begin
        dst_kind = rm_k; dst_reg = rm_r; dst_data = rm_d;
        src_kind = rg_k; src_reg = rg_r; src_data = rg_d;
      end
      FORM_REG_RM: begin
        dst_kind = rg_k; dst_reg = rg_r; dst_data = rg_d;
        src_kind = rm_k; src_reg = rm_r; src_data = rm_d;
      end
      default: begin
        dst_kind = im_k; dst_reg = im_r; dst_data = im_d;
        src_kind = im_k; src_reg = im_r; src_data = im_d;
      end
    endcase
    lea = (src_kind == KIND_MEM) ? src_data : '0;
  end

  // R6
  always_comb begin
    kind_code_chk: assert (dst_kind != 2'b11 && src_kind != 2'b11);
  end

endmodule

// File: rtl/scaled_agu.sv
module scaled_agu
  import agu_pkg::*;
#(
  parameter int AW  = 32,
  parameter int RNW = 3,
  parameter int SCW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [1:0]     form,
  input  logic           rm_is_mem,
  input  logic [RNW-1:0] rm_reg,
  input  logic           base_en,
  input  logic [AW-1:0]  base_val,
  input  logic           idx_en,
  input  logic [AW-1:0]  idx_val,
  input  logic [SCW-1:0] scale,
  input  logic [AW-1:0]  disp,
  input  logic [RNW-1:0] reg_num,
  input  logic [AW-1:0]  imm,
  input  logic           dst_wr,
  output logic           out_valid,
  output logic [1:0]     dst_kind,
  output logic [RNW-1:0] dst_reg,
  output logic [AW-1:0]  dst_data,
  output logic [1:0]     src_kind,
  output logic [RNW-1:0] src_reg,
  output logic [AW-1:0]  src_data,
  output logic [AW-1:0]  lea_addr,
  output logic           wr_err
);

  logic [AW-1:0]  ea;
  logic [1:0]     c_dk, c_sk;
  logic [RNW-1:0] c_dr, c_sr;
  logic [AW-1:0]  c_dd, c_sd, c_lea;

  agu_ea_calc #(.AW(AW), .SCW(SCW)) u_ea (
    .base_en  (base_en),
    .base_val (base_val),
    .idx_en   (idx_en),
    .idx_val  (idx_val),
    .scale    (scale),
    .disp     (disp),
    .addr     (ea)
  );

  agu_operand_sel #(.AW(AW), .RNW(RNW)) u_sel (
    .form      (form),
    .rm_is_mem (rm_is_mem),
    .rm_reg    (rm_reg),
    .rm_addr   (ea),
    .reg_num   (reg_num),
    .imm       (imm),
    .dst_kind  (c_dk),
    .dst_reg   (c_dr),
    .dst_data  (c_dd),
    .src_kind  (c_sk),
    .src_reg   (c_sr),
    .src_data  (c_sd),
    .lea       (c_lea)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      wr_err    <= 1'b0;
      dst_kind  <= '0;
      dst_reg   <= '0;
      dst_data  <= '0;
      src_kind  <= '0;
      src_reg   <= '0;
      src_data  <= '0;
      lea_addr  <= '0;
    end else begin
      out_valid <= in_valid;
      wr_err    <= in_valid && dst_wr && (c_dk == KIND_IMM);
      if (in_valid) begin
        dst_kind <= c_dk;
        dst_reg  <= c_dr;
        dst_data <= c_dd;
        src_kind <= c_sk;
        src_reg  <= c_sr;
        src_data <= c_sd;
        lea_addr <= c_lea;
      end
    end
  end

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R10
  idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !wr_err));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(dst_data) && $stable(src_data) && $stable(lea_addr)));

  // R9
  wr_err_kind_chk: assert property (@(posedge clk) disable iff (rst)
    wr_err |-> (out_valid && dst_kind == KIND_IMM));

  // R7
  lea_nonmem_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && src_kind != KIND_MEM) |-> (lea_addr == '0));

  // R8
  imm_dst_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && dst_kind == KIND_IMM) |-> (src_kind == KIND_IMM));

endmodule

// File: tb/sim_scaled_agu.sv
module sim_scaled_agu;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  form;
  logic        rm_is_mem;
  logic [2:0]  rm_reg;
  logic        base_en;
  logic [31:0] base_val;
  logic        idx_en;
  logic [31:0] idx_val;
  logic [1:0]  scale;
  logic [31:0] disp;
  logic [2:0]  reg_num;
  logic [31:0] imm;
  logic        dst_wr;
  logic        out_valid;
  logic [1:0]  dst_kind, src_kind;
  logic [2:0]  dst_reg, src_reg;
  logic [31:0] dst_data, src_data, lea_addr;
  logic        wr_err;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;

  logic [1:0]  e_dk, e_sk;
  logic [2:0]  e_dr, e_sr;
  logic [31:0] e_dd, e_sd, e_lea;
  logic        e_err;

  always #10 clk = ~clk;

  scaled_agu u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .form(form),
    .rm_is_mem(rm_is_mem), .rm_reg(rm_reg), .base_en(base_en),
    .base_val(base_val), .idx_en(idx_en), .idx_val(idx_val),
    .scale(scale), .disp(disp), .reg_num(reg_num), .imm(imm),
    .dst_wr(dst_wr), .out_valid(out_valid), .dst_kind(dst_kind),
    .dst_reg(dst_reg), .dst_data(dst_data), .src_kind(src_kind),
    .src_reg(src_reg), .src_data(src_data), .lea_addr(lea_addr),
    .wr_err(wr_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference model: multiply and add, independent of the shift structure
  task automatic model();
    logic [31:0] a;
    logic [1:0]  rk;
    logic [2:0]  rr;
    logic [31:0] rd;
    a = (idx_en ? idx_val * (32'd1 << scale) : 32'd0)
      + (base_en ? base_val : 32'd0) + disp;
    if (rm_is_mem) begin rk = 2'b10; rr = 3'd0;   rd = a;     end
    else           begin rk = 2'b01; rr = rm_reg; rd = 32'd0; end
    case (form)
      2'b00: begin e_dk = rk; e_dr = rr; e_dd = rd; e_sk = 2'b00; e_sr = 3'd0; e_sd = imm; end
      2'b01: begin e_dk = rk; e_dr = rr; e_dd = rd; e_sk = 2'b01; e_sr = reg_num; e_sd = 32'd0; end
      2'b10: begin e_dk = 2'b01; e_dr = reg_num; e_dd = 32'd0; e_sk = rk; e_sr = rr; e_sd = rd; end
      default: begin e_dk = 2'b00; e_dr = 3'd0; e_dd = imm; e_sk = 2'b00; e_sr = 3'd0; e_sd = imm; end
    endcase
    e_lea = (e_sk == 2'b10) ? e_sd : 32'd0;
    e_err = dst_wr && (e_dk == 2'b00);
  endtask

  // drive at a falling edge, check at the next falling edge (one register)
  task automatic run(input string tag);
    in_valid = 1'b1;
    model();
    @(negedge clk);
    chk({tag, " R10 valid"}, {31'd0, out_valid}, 32'd1);
    chk({tag, " R6 R8 dst_kind"}, {30'd0, dst_kind}, {30'd0, e_dk});
    chk({tag, " R6 R8 dst_reg"}, {29'd0, dst_reg}, {29'd0, e_dr});
    chk({tag, " R2 R5 R8 dst_data"}, dst_data, e_dd);
    chk({tag, " R6 R8 src_kind"}, {30'd0, src_kind}, {30'd0, e_sk});
    chk({tag, " R6 R8 src_reg"}, {29'd0, src_reg}, {29'd0, e_sr});
    chk({tag, " R2 R5 R8 src_data"}, src_data, e_sd);
    chk({tag, " R7 lea"}, lea_addr, e_lea);
    chk({tag, " R9 err"}, {31'd0, wr_err}, {31'd0, e_err});
  endtask

  task automatic mem_src(input logic be, input logic [31:0] b, input logic ie,
                         input logic [31:0] x, input logic [1:0] s, input logic [31:0] d);
    form = 2'b10; rm_is_mem = 1'b1; dst_wr = 1'b1;
    base_en = be; base_val = b; idx_en = ie; idx_val = x; scale = s; disp = d;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] hold_d, hold_s, hold_l;
    void'($urandom(32'd20240607));
    rst = 1'b1; in_valid = 1'b1; form = 2'b11; rm_is_mem = 1'b0; rm_reg = 3'd5;
    base_en = 1'b1; base_val = 32'h1111; idx_en = 1'b1; idx_val = 32'h22;
    scale = 2'd1; disp = 32'h4; reg_num = 3'd2; imm = 32'hABCD; dst_wr = 1'b1;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 valid", {31'd0, out_valid}, 32'd0);
    chk("R1 err", {31'd0, wr_err}, 32'd0);
    chk("R1 dst_data", dst_data, 32'd0);
    chk("R1 src_data", src_data, 32'd0);
    chk("R1 lea", lea_addr, 32'd0);
    chk("R1 kinds", {28'd0, dst_kind, src_kind}, 32'd0);
    rst = 1'b0;

    // R2 each scale code, R5 sum
    for (int s = 0; s < 4; s++) begin
      mem_src(1'b1, 32'h1000, 1'b1, 32'h10, 2'(s), 32'h8);
      run("R2 scale");
    end
    // R3 index absent
    mem_src(1'b1, 32'h5000, 1'b0, 32'hFFFF_FFFF, 2'd3, 32'h10);
    run("R3 no index");
    // R4 base absent
    mem_src(1'b0, 32'hDEAD_BEEF, 1'b1, 32'h40, 2'd2, 32'h3);
    run("R4 no base");
    // both absent: displacement only
    mem_src(1'b0, 32'h1234, 1'b0, 32'h5678, 2'd1, 32'h0BAD_F00D);
    run("R3 R4 disp only");
    // R5 wrap
    mem_src(1'b1, 32'hFFFF_FFFF, 1'b1, 32'h2000_0000, 2'd3, 32'h1);
    run("R5 wrap");
    mem_src(1'b1, 32'h8000_0000, 1'b0, 32'h0, 2'd0, 32'h8000_0000);
    run("R5 wrap2");
    // R7 lea zero when source is register
    form = 2'b10; rm_is_mem = 1'b0; rm_reg = 3'd6; run("R7 reg src");
    // R8 each form, R6 register/immediate locations
    form = 2'b00; rm_is_mem = 1'b1; run("R8 rm_imm");
    form = 2'b01; rm_is_mem = 1'b0; run("R8 rm_reg");
    // R9 immediate destination with and without write intent
    form = 2'b11; dst_wr = 1'b1; run("R9 imm write");
    form = 2'b11; dst_wr = 1'b0; run("R9 imm nowrite");
    form = 2'b00; dst_wr = 1'b1; run("R9 rm write");

    // R10 idle cycle: outputs hold, valid and err clear
    form = 2'b11; dst_wr = 1'b1; imm = 32'h7777; run("R10 pre idle");
    hold_d = dst_data; hold_s = src_data; hold_l = lea_addr;
    in_valid = 1'b0; form = 2'b10; rm_is_mem = 1'b1; imm = 32'h9999; disp = 32'h55;
    @(negedge clk);
    chk("R10 idle valid", {31'd0, out_valid}, 32'd0);
    chk("R10 idle err", {31'd0, wr_err}, 32'd0);
    chk("R10 idle dst", dst_data, hold_d);
    chk("R10 idle src", src_data, hold_s);
    chk("R10 idle lea", lea_addr, hold_l);

    // random mix
    for (int i = 0; i < 1500; i++) begin
      form = 2'($urandom); rm_is_mem = 1'($urandom); rm_reg = 3'($urandom);
      base_en = 1'($urandom); base_val = $urandom; idx_en = 1'($urandom);
      idx_val = $urandom; scale = 2'($urandom); disp = $urandom;
      reg_num = 3'($urandom); imm = $urandom; dst_wr = 1'($urandom);
      run("rand");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule